// File: doc/BRIEF.md
# Two-Write-Port Memory with Configurable Read Bypass

This block is a small register-file style memory. It has several write ports, two by default, and one registered read port. Everything runs on a single rising clock edge. Each write port has its own address, data word and per-bit write mask. The read port takes an address and a read enable, and it returns the addressed word one cycle later through an output register.

When the read address matches an address that a write port is updating in the same cycle, what the read returns depends on that write port's setting:

- **Transparent:** the freshly written bits come out.
- **Non-transparent:** the previous contents come out.
- **Don't-care:** the value returned is unspecified.

Write ports are ordered. The port with the higher index wins both in storage and on the bypass path, so the two paths always agree. A port cannot be both transparent and don't-care; that setting stops elaboration with an error.

The read register has a synchronous reset that loads a parameter value. Reset has priority over the read enable. The data paths are plain, with no valid/ready, because a memory port accepts every cycle and has no back-pressure.

Top module: `mwb_mem`

## Requirements
- R1: With `rd_en` high, `rst` low and no write port hitting `rd_addr`, `rd_data` shows the stored word at `rd_addr` one cycle later.
- R2: A transparent write port whose address equals `rd_addr` while `rd_en` is high puts its new data on `rd_data` one cycle later. This applies only to the bits whose `wr_mask` bit is 1; the other bits show the stored value.
- R3: A non-transparent write port hitting `rd_addr` leaves `rd_data` at the value stored before that write.
- R4: When two write ports update the same address, each bit written by both ports takes the data of the port with the higher index. A bit written by only one port takes that port's data.
- R5: When both ports are transparent and both hit `rd_addr`, `rd_data` equals the word the storage holds after the write, so the higher-index port wins.
- R6: With `rst` high, `rd_data` becomes `RST_VAL` after the edge, whatever `rd_en` and the write ports do. Writes to storage still take effect during reset.
- R7: With `rd_en` low and `rst` low, `rd_data` keeps its value, even while a transparent port writes to `rd_addr`.
- R8: A write port with a nonzero mask but a different address from `rd_addr` has no effect on `rd_data`.
- R9: A don't-care port hitting `rd_addr` makes only that cycle's read unspecified. Its write lands in storage, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all ports sample on the rising edge |
| rst | input | 1 | Synchronous reset of the read register, active high |
| wr_mask | input | NWR*DW | Per-port, per-bit write enables (port p in bits [p*DW +: DW]) |
| wr_addr | input | NWR*AW | Per-port write address |
| wr_data | input | NWR*DW | Per-port write data |
| rd_en | input | 1 | Read enable; the read register loads only when high |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |

## Verification
Two instances share one stimulus stream:

- One instance has both ports transparent.
- The other has port 0 non-transparent and port 1 don't-care.

The bench sweeps every port-0 mask against several port-1 masks. It crosses each mask pair with the four address patterns: no port hits the read address, only port 0 hits, only port 1 hits, and both hit.

Each pattern separates a different source for each output bit: stored data, port-0 data, or port-1 data. An immediate re-read of the same address then separates the storage result from the bypass result.

Separate short sequences cover four further cases: holding with the read enable low, reset overriding a bypassing read, a write to a different address, and recovery after a don't-care collision.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  typedef enum logic [1:0] {
    MWB_KEEP_OLD = 2'd0,
    MWB_PASS_NEW = 2'd1,
    MWB_ANY      = 2'd2
  } mwb_mode_e;

  // Collision behaviour of one write port, derived from its two config bits.
  function automatic mwb_mode_e mwb_mode(input logic pass_new, input logic any_val);
    if (any_val)  return MWB_ANY;
    if (pass_new) return MWB_PASS_NEW;
    return MWB_KEEP_OLD;
  endfunction

endpackage

// File: rtl/mwb_store.sv
module mwb_store #(
  parameter int NWR = 2,
  parameter int AW  = 4,
  parameter int DW  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0][DW-1:0]  wr_mask,
  input  logic [NWR-1:0][AW-1:0]  wr_addr,
  input  logic [NWR-1:0][DW-1:0]  wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Ports applied in ascending index: the later one overrides per bit.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NWR; p++) begin
      for (int b = 0; b < DW; b++) begin
        if (wr_mask[p][b]) mem[wr_addr[p]][b] <= wr_data[p][b];
      end
    end
  end

  assign rd_word = mem[rd_addr];

  generate
    if (NWR >= 2) begin : g_order_chk
      // R4: bits written by the top two ports at one address keep the top port's data
      a_r4_higher_port_wins: assert property (@(posedge clk) disable iff (rst)
        ((wr_addr[NWR-1] == wr_addr[NWR-2]) && (|(wr_mask[NWR-1] & wr_mask[NWR-2])))
        |=> ((mem[$past(wr_addr[NWR-1])] & $past(wr_mask[NWR-1] & wr_mask[NWR-2])) ==
             ($past(wr_data[NWR-1]) & $past(wr_mask[NWR-1] & wr_mask[NWR-2]))));
    end
  endgenerate

endmodule

// File: rtl/mwb_bypass.sv
module mwb_bypass
  import mwb_pkg::*;
#(
  parameter int NWR = 2,
  parameter int AW  = 4,
  parameter int DW  = 4,
  parameter logic [NWR-1:0] TRANSPARENT = '1,
  parameter logic [NWR-1:0] COLLISION_X = '0
) (
  input  logic [DW-1:0]           stored_word,
  input  logic [AW-1:0]           rd_addr,
  input  logic [NWR-1:0][DW-1:0]  wr_mask,
  input  logic [NWR-1:0][AW-1:0]  wr_addr,
  input  logic [NWR-1:0][DW-1:0]  wr_data,
  output logic [DW-1:0]           word_o
);
  // Mux chain in port order so that the bypass priority equals the write priority.
  // Don't-care ports are free to return anything; the old word is the cheapest.
  always_comb begin
    word_o = stored_word;
    for (int p = 0; p < NWR; p++) begin
      if (mwb_mode(TRANSPARENT[p], COLLISION_X[p]) == MWB_PASS_NEW &&
          wr_addr[p] == rd_addr) begin
        word_o = (word_o & ~wr_mask[p]) | (wr_data[p] & wr_mask[p]);
      end
    end
  end

endmodule

// File: rtl/mwb_rdreg.sv
module mwb_rdreg #(
  parameter int DW = 4,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (en) q <= d;
  end

  // R6: reset loads the reset value regardless of enable
  a_r6_reset_value: assert property (@(posedge clk) rst |=> (q == RST_VAL));
  // R7: disabled read holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q));

endmodule

// File: rtl/mwb_mem.sv
module mwb_mem #(
  parameter int NWR = 2,
  parameter int AW  = 4,
  parameter int DW  = 4,
  parameter logic [NWR-1:0] TRANSPARENT = '1,
  parameter logic [NWR-1:0] COLLISION_X = '0,
  parameter logic [DW-1:0]  RST_VAL     = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0][DW-1:0]  wr_mask,
  input  logic [NWR-1:0][AW-1:0]  wr_addr,
  input  logic [NWR-1:0][DW-1:0]  wr_data,
  input  logic                    rd_en,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data
);
  generate
    if ((TRANSPARENT & COLLISION_X) != '0) begin : g_bad_cfg
      $error("mwb_mem: a write port cannot be both transparent and don't-care");
    end
  endgenerate

  logic [DW-1:0] stored_word;
  logic [DW-1:0] next_word;

  mwb_store #(.NWR(NWR), .AW(AW), .DW(DW)) store_i (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (wr_mask),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_word (stored_word)
  );

  mwb_bypass #(
    .NWR(NWR), .AW(AW), .DW(DW),
    .TRANSPARENT(TRANSPARENT), .COLLISION_X(COLLISION_X)
  ) bypass_i (
    .stored_word (stored_word),
    .rd_addr     (rd_addr),
    .wr_mask     (wr_mask),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .word_o      (next_word)
  );

  mwb_rdreg #(.DW(DW), .RST_VAL(RST_VAL)) rdreg_i (
    .clk (clk),
    .rst (rst),
    .en  (rd_en),
    .d   (next_word),
    .q   (rd_data)
  );

  logic [NWR-1:0] port_hit;
  for (genvar p = 0; p < NWR; p++) begin : g_hit
    assign port_hit[p] = (|wr_mask[p]) && (wr_addr[p] == rd_addr);
  end

  // R1 / R8: with no hitting write, the register takes the stored word
  a_r1_plain_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_hit == '0) |=> (rd_data == $past(stored_word)));

  generate
    if (TRANSPARENT[NWR-1]) begin : g_top_pass_chk
      // R2: a full-width write on the top transparent port is seen on the next read
      a_r2_full_write_seen: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_addr[NWR-1] == rd_addr && (&wr_mask[NWR-1]))
        |=> (rd_data == $past(wr_data[NWR-1])));
    end
  endgenerate

endmodule

// File: tb/mwb_mem_tb.sv
`timescale 1ns/1ps
module mwb_mem_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst;
  logic [1:0][3:0] wr_mask;
  logic [1:0][3:0] wr_addr;
  logic [1:0][3:0] wr_data;
  logic            rd_en;
  logic [3:0]      rd_addr;
  logic [3:0]      rd_i, rd_b;

  // both ports transparent
  mwb_mem #(.NWR(2), .AW(4), .DW(4), .TRANSPARENT(2'b11), .COLLISION_X(2'b00),
            .RST_VAL(4'hA)) dut_i (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_i));

  // port 0 non-transparent, port 1 don't-care
  mwb_mem #(.NWR(2), .AW(4), .DW(4), .TRANSPARENT(2'b00), .COLLISION_X(2'b10),
            .RST_VAL(4'h5)) dut_b (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_b));

  int checks = 0;
  int errors = 0;
  logic [3:0] model [16];
  logic [3:0] exp_i = 4'h0;
  logic [3:0] exp_b = 4'h0;
  bit b_known = 1'b0;

  task automatic check(input string tag, input string who, input logic [3:0] act,
                       input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, who, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit re, input logic [3:0] ra,
                      input logic [3:0] m0, input logic [3:0] a0, input logic [3:0] d0,
                      input logic [3:0] m1, input logic [3:0] a1, input logic [3:0] d1,
                      input string tag_i, input string tag_b, input bit do_check);
    logic [3:0] old;
    rst = r; rd_en = re; rd_addr = ra;
    wr_mask[0] = m0; wr_addr[0] = a0; wr_data[0] = d0;
    wr_mask[1] = m1; wr_addr[1] = a1; wr_data[1] = d1;
    old = model[ra];
    if (r) begin
      exp_i = 4'hA; exp_b = 4'h5; b_known = 1'b1;
    end else if (re) begin
      exp_i = old;
      if (a0 == ra) exp_i = (exp_i & ~m0) | (d0 & m0);
      if (a1 == ra) exp_i = (exp_i & ~m1) | (d1 & m1);
      exp_b = old;
      b_known = !((a1 == ra) && (m1 != 4'h0));
    end
    model[a0] = (model[a0] & ~m0) | (d0 & m0);
    model[a1] = (model[a1] & ~m1) | (d1 & m1);
    @(posedge clk);
    @(negedge clk);
    if (do_check) begin
      check(tag_i, "dut_i", rd_i, exp_i);
      if (b_known) check(tag_b, "dut_b", rd_b, exp_b);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16; a++) model[a] = 4'h0;
    rst = 1'b1; rd_en = 1'b0; rd_addr = '0; wr_mask = '0; wr_addr = '0; wr_data = '0;
    @(negedge clk);
    // R6: reset state
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R6", "R6", 1);
    // fill storage, reads disabled: R7 hold of the reset value
    for (int a = 0; a < 16; a++)
      step(0, 0, 4'(a), 4'hF, 4'(a), 4'(a * 7 + 3), 4'h0, 4'(a), 4'h0, "R7", "R7", 1);
    // R1: plain reads of every entry
    for (int a = 0; a < 16; a++)
      step(0, 1, 4'(a), 0, 0, 0, 0, 0, 0, "R1", "R1", 1);

    // sweep masks x address-hit patterns; each followed by a storage re-read (R4)
    for (int m0 = 0; m0 < 16; m0++) begin
      for (int k = 0; k < 4; k++) begin
        for (int pat = 0; pat < 4; pat++) begin
          logic [3:0] ra, a0, a1, d0, d1, mm1;
          string ti, tb;
          mm1 = 4'(k * 5);
          ra  = 4'(m0 + k * 4 + pat);
          a0  = pat[0] ? ra : ra + 4'd1;
          a1  = pat[1] ? ra : ra + 4'd3;
          d0  = 4'(m0 * 3 + ra);
          d1  = ~d0 ^ 4'(pat);
          if (pat == 3 && (4'(m0) & mm1) != 0)             ti = "R5";
          else if ((pat[0] && m0 != 0) || (pat[1] && mm1 != 0)) ti = "R2";
          else                                               ti = "R8";
          tb = (pat[0] && m0 != 0) ? "R3" : "R1";
          step(0, 1, ra, 4'(m0), a0, d0, mm1, a1, d1, ti, tb, 1);
          step(0, 1, ra, 0, 0, 0, 0, 0, 0, "R4", "R4", 1);
        end
      end
    end

    // R7: transparent write to the read address while disabled: output holds
    step(0, 1, 4'h6, 0, 0, 0, 0, 0, 0, "R1", "R1", 1);
    step(0, 0, 4'h6, 4'hF, 4'h6, 4'h9, 4'hF, 4'h6, 4'h3, "R7", "R7", 1);
    step(0, 1, 4'h6, 0, 0, 0, 0, 0, 0, "R4", "R4", 1);
    // R6: reset wins over an enabled, bypassing read; the write still lands
    step(1, 1, 4'h2, 4'hF, 4'h2, 4'hC, 4'h0, 4'h0, 4'h0, "R6", "R6", 1);
    step(0, 1, 4'h2, 0, 0, 0, 0, 0, 0, "R6", "R6", 1);
    // R8: write elsewhere does not disturb the read
    step(0, 1, 4'h4, 4'hF, 4'h5, 4'h1, 4'hF, 4'h3, 4'h2, "R8", "R8", 1);
    // R9: don't-care collision on dut_b, then the write is readable
    step(0, 1, 4'h8, 4'h0, 4'h0, 4'h0, 4'hF, 4'h8, 4'h7, "R2", "R9", 1);
    step(0, 1, 4'h8, 0, 0, 0, 0, 0, 0, "R9", "R9", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule